// File: doc/BRIEF.md
# Cache Set/Way Maintenance Walker

This block drives a whole-cache maintenance pass over an 8-way set-associative cache. A single start request, together with a geometry word and a one-bit operation select, launches a walk. The block reads the number of sets from the geometry word, then sends one command for every set/way pair on a valid/ready command port.

Each command carries a packed set/way operand and the operation that was latched at start. The operation is either invalidate or clean-and-invalidate. After the final command has been accepted, a one-cycle completion pulse marks the point where a barrier may be issued. If the geometry word reports that no cache is fitted, no command is sent and completion follows at once. The cache arrays sit outside this block and receive the commands.

Top module: `sw_walker`

## Requirements
- R1: While reset is held and in the first cycle after reset, busy_o, cmd_valid_o and done_o are all low.
- R2: The 4-bit size field geom_i[11:8] (value f) gives a way size of 8192<<f bytes. With 32-byte lines, a walk therefore sends exactly 8*(256<<f) commands.
- R3: cmd_operand_o equals way*2^29 + set*2^5. The way index fills bits [31:29], the set index starts at bit 5, and every other bit is zero.
- R4: Walk order is set-major. Ways 0 through 7 of set s are sent in turn, and only then does the walk move to set s+1. The first command is set 0, way 0.
- R5: A cache is present only when some bit of geom_i[7:3] is 1. If none is set, an accepted start produces no command, and done_o is high in the cycle after start.
- R6: done_o is high for exactly one cycle. That cycle is the one right after the edge where the final command is accepted.
- R7: busy_o rises in the cycle after an accepted start. It stays high through the done_o cycle and is low in the cycle after that.
- R8: A start_i that is high while busy_o is high has no effect on the walk in progress, and it does not begin a new walk.
- R9: While cmd_valid_o is high and cmd_ready_i is low, the operand and operation stay unchanged. The walk advances only on an edge where both are high.
- R10: cmd_op_o shows the op_i value sampled at the accepted start, with 0 for invalidate and 1 for clean-and-invalidate. It stays constant for the whole walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a walk; taken only when idle |
| op_i | input | 1 | Operation select: 0 invalidate, 1 clean-and-invalidate |
| geom_i | input | 32 | Geometry word: presence bits [7:3], size field [11:8] |
| busy_o | output | 1 | High from the cycle after start through the done cycle |
| cmd_valid_o | output | 1 | Command available |
| cmd_ready_i | input | 1 | Command accepted when high together with cmd_valid_o |
| cmd_operand_o | output | 32 | Packed set/way operand |
| cmd_op_o | output | 1 | Latched operation of the current walk |
| done_o | output | 1 | One-cycle completion / barrier pulse |

## Verification
A new start request can land on the same edge as the acceptance of the final command. It can also land during the completion cycle. In both cases the walker is still busy, so the request must be dropped. The bench holds start_i high across the last handshake and across the done cycle, then checks two things: done_o pulses once, and the two cycles that follow show busy_o and cmd_valid_o low with no new walk under way. Other walks send start requests with the opposite operation at random cycles, and those walks must keep both their operand sequence and their opcode.

// File: rtl/sw_walk_pkg.sv
package sw_walk_pkg;
  localparam int LINE_SHIFT = 5;
  localparam int WAY_W      = 3;
  localparam int WAY_POS    = 29;
  localparam int BASE_LOG2  = 8;
  localparam int FIELD_LSB  = 8;
  localparam int FIELD_W    = 4;
  localparam int PRES_LO    = 3;
  localparam int PRES_HI    = 7;
  localparam int GEOM_W     = 32;
  localparam int OPND_W     = 32;
  localparam int FIELD_MAX  = (1 << FIELD_W) - 1;
  localparam int SET_W      = BASE_LOG2 + FIELD_MAX;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} walk_st_e;

  function automatic logic [SET_W-1:0] set_max_of(input logic [FIELD_W-1:0] f);
    return {SET_W{1'b1}} >> (FIELD_W'(FIELD_MAX) - f);
  endfunction

  function automatic logic [OPND_W-1:0] pack_sw(input logic [WAY_W-1:0] w,
                                               input logic [SET_W-1:0] s);
    return (OPND_W'(w) << WAY_POS) | (OPND_W'(s) << LINE_SHIFT);
  endfunction
endpackage

// File: rtl/sw_geom_dec.sv
module sw_geom_dec
  import sw_walk_pkg::*;
(
  input  logic [GEOM_W-1:0] geom_i,
  output logic              present_o,
  output logic [SET_W-1:0]  set_max_o
);
  logic [FIELD_W-1:0] size_field;
  logic               unused_geom;

  assign size_field  = geom_i[FIELD_LSB +: FIELD_W];
  assign present_o   = |geom_i[PRES_HI:PRES_LO];
  assign set_max_o   = set_max_of(size_field);
  assign unused_geom = ^{geom_i[GEOM_W-1:FIELD_LSB+FIELD_W], geom_i[PRES_LO-1:0]};
endmodule

// File: rtl/sw_idx_ctr.sv
module sw_idx_ctr
  import sw_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [SET_W-1:0] set_max_i,
  output logic [WAY_W-1:0] way_o,
  output logic [SET_W-1:0] set_o,
  output logic             at_last_o
);
  localparam logic [WAY_W-1:0] WAY_LAST = {WAY_W{1'b1}};

  logic [SET_W-1:0] set_max_q;
  logic             way_wrap;

  assign way_wrap  = (way_o == WAY_LAST);
  assign at_last_o = way_wrap && (set_o == set_max_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      way_o     <= '0;
      set_o     <= '0;
      set_max_q <= '0;
    end else if (clear_i) begin
      way_o     <= '0;
      set_o     <= '0;
      set_max_q <= set_max_i;
    end else if (step_i) begin
      way_o <= way_o + 1'b1;
      if (way_wrap) set_o <= set_o + 1'b1;
    end
  end
endmodule

// File: rtl/sw_walker.sv
module sw_walker
  import sw_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [GEOM_W-1:0] geom_i,
  output logic              busy_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [OPND_W-1:0] cmd_operand_o,
  output logic              cmd_op_o,
  output logic              done_o
);
  walk_st_e         state_q, state_d;
  logic             present;
  logic [SET_W-1:0] set_max;
  logic [WAY_W-1:0] way_idx;
  logic [SET_W-1:0] set_idx;
  logic             at_last;
  logic             op_q;

  // named internal events, observed by the bound checker
  logic start_take;
  logic cmd_fire;
  logic walk_last;

  sw_geom_dec u_dec (
    .geom_i    (geom_i),
    .present_o (present),
    .set_max_o (set_max)
  );

  sw_idx_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_take),
    .step_i    (cmd_fire),
    .set_max_i (set_max),
    .way_o     (way_idx),
    .set_o     (set_idx),
    .at_last_o (at_last)
  );

  assign start_take    = start_i && (state_q == ST_IDLE);
  assign cmd_valid_o   = (state_q == ST_WALK);
  assign cmd_fire      = cmd_valid_o && cmd_ready_i;
  assign walk_last     = cmd_fire && at_last;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign cmd_operand_o = pack_sw(way_idx, set_idx);
  assign cmd_op_o      = op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_take) state_d = present ? ST_WALK : ST_DONE;
      ST_WALK: if (walk_last)  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_take) op_q <= op_i;
    end
  end
endmodule

// File: rtl/sw_walker_chk.sv
module sw_walker_chk
  import sw_walk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [OPND_W-1:0] cmd_operand_o,
  input logic              cmd_op_o,
  input logic              done_o,
  input logic              start_take,
  input logic              present
);
  localparam logic [OPND_W-1:0] WAY_MASK = ((OPND_W'(1) << WAY_W) - 1) << WAY_POS;
  localparam logic [OPND_W-1:0] SET_MASK = ((OPND_W'(1) << SET_W) - 1) << LINE_SHIFT;
  localparam logic [OPND_W-1:0] ZERO_MASK = ~(WAY_MASK | SET_MASK);

  assert_operand_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ((cmd_operand_o & ZERO_MASK) == '0));

  assert_absent_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && !present) |=> (!cmd_valid_o && done_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || cmd_valid_o) |-> busy_o);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> busy_o);

  assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_operand_o) && $stable(cmd_op_o)));

  assert_op_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(cmd_op_o)));
endmodule

bind sw_walker sw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_o        (busy_o),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_ready_i   (cmd_ready_i),
  .cmd_operand_o (cmd_operand_o),
  .cmd_op_o      (cmd_op_o),
  .done_o        (done_o),
  .start_take    (start_take),
  .present       (present)
);

// File: tb/sim_sw_walker.sv
module sim_sw_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] geom_i = '0;
  logic        busy_o, cmd_valid_o, cmd_op_o, done_o;
  logic        cmd_ready_i = 1'b0;
  logic [31:0] cmd_operand_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  sw_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .geom_i(geom_i),
    .busy_o(busy_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_operand_o(cmd_operand_o), .cmd_op_o(cmd_op_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint exp_cmds(input logic [31:0] g);
    longint way_bytes = longint'(8192) * (longint'(1) << g[11:8]);
    return (way_bytes / 32) * 8;
  endfunction

  function automatic longint exp_opnd(input longint way, input longint set);
    return way * 536870912 + set * 32;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    finished = 1;
    $finish;
  endtask

  // one full walk; ready_pct = chance of ready per cycle, noise = random starts mid-walk
  task automatic run_walk(input logic [31:0] g, input bit op, input int ready_pct,
                          input bit noise, input bit hold_start);
    longint total = exp_cmds(g);
    longint n = 0;
    bit rdy;
    @(negedge clk);
    geom_i = g; op_i = op; start_i = 1'b1;
    @(negedge clk);
    start_i = hold_start;
    op_i = ~op;
    chk(busy_o === 1'b1, "R7 busy after start", longint'(busy_o), 1);
    while (n < total) begin
      chk(cmd_valid_o === 1'b1, "R9 valid during walk", longint'(cmd_valid_o), 1);
      // R3 / R4: set-major order, packed operand
      chk(longint'(cmd_operand_o) == exp_opnd(n % 8, n / 8), "R3 R4 operand",
          longint'(cmd_operand_o), exp_opnd(n % 8, n / 8));
      chk(cmd_op_o === op, "R10 opcode", longint'(cmd_op_o), longint'(op));
      chk(done_o === 1'b0, "R6 no early done", longint'(done_o), 0);
      rdy = ($urandom % 100) < ready_pct;
      cmd_ready_i = rdy;
      // R8: start requests while busy must be ignored
      start_i = noise ? (($urandom % 4) == 0) : hold_start;
      @(negedge clk);
      if (rdy) n++;
    end
    cmd_ready_i = 1'b0;
    // R2: the exact count was consumed, now done
    chk(done_o === 1'b1, "R2 R6 done after last", longint'(done_o), 1);
    chk(cmd_valid_o === 1'b0, "R2 no extra command", longint'(cmd_valid_o), 0);
    chk(busy_o === 1'b1, "R7 busy in done cycle", longint'(busy_o), 1);
    start_i = hold_start;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b0, "R6 done single cycle", longint'(done_o), 0);
    chk(busy_o === 1'b0, "R7 busy falls", longint'(busy_o), 0);
    @(negedge clk);
    chk(busy_o === 1'b0 && cmd_valid_o === 1'b0, "R8 no restart from held start",
        longint'({busy_o, cmd_valid_o}), 0);
  endtask

  task automatic run_absent(input logic [31:0] g);
    @(negedge clk);
    geom_i = g; op_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b1, "R5 done at once", longint'(done_o), 1);
    chk(cmd_valid_o === 1'b0, "R5 no command", longint'(cmd_valid_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0 && cmd_valid_o === 1'b0, "R5 back to idle",
        longint'({done_o, busy_o, cmd_valid_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && cmd_valid_o === 1'b0 && done_o === 1'b0, "R1 in reset",
        longint'({busy_o, cmd_valid_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0 && cmd_valid_o === 1'b0 && done_o === 1'b0, "R1 after reset",
        longint'({busy_o, cmd_valid_o, done_o}), 0);
    run_walk(32'h0000_0008, 1'b0, 100, 1'b0, 1'b0);
    run_walk(32'h0000_0180, 1'b1, 60, 1'b1, 1'b0);
    run_walk(32'h0000_0010, 1'b1, 100, 1'b0, 1'b1);
    run_walk(32'hFFFF_F0F8 & 32'h0000_02F8, 1'($urandom % 2), 80, 1'b1, 1'b0);
    run_absent(32'hFFFF_FF07);
    run_absent(32'h0000_0000);
    run_walk(32'h0000_0040, 1'b0, 30, 1'b1, 1'b1);
    finish_up();
  end
endmodule